// File: doc/BRIEF.md
# Interleaved Read Bank Controller with Per-Bank Address Latches

This block is a read-only memory split into `2**BANK_BITS` banks with low-order interleaving. The lowest address bits pick a bank and the remaining upper bits pick a word inside that bank. Every bank latches its own location in a private address register when it takes a request. A bank then stays occupied for `LAT` cycles, and its word is driven straight from its storage when the access finishes. There is no per-bank data holding register. Because each bank latches its address on its own, accesses to different banks overlap in any order. Strided or scattered address streams are served just as well as linear ones.

One request can be offered per cycle on a valid/ready pair. If the target bank is still occupied, `req_ready` drops and the request waits. Accepted requests are recorded in a small in-order queue of bank numbers. Each response comes back exactly `LAT` cycles after acceptance, in acceptance order. It carries the address it was issued for and the word read from that address. The stored contents are a fixed, computed pattern, so every read can be checked.

Top module: `ilv_bank_ctrl`

## Requirements
- R1: Bank number is `req_addr[BANK_BITS-1:0]`. The word inside that bank is `req_addr[ADDR_W-1:BANK_BITS]`.
- R2: `req_ready` is low exactly when the addressed bank accepted a request on one of the previous `LAT-1` clock edges. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- R3: A request accepted on edge T produces `rsp_valid` high for exactly one cycle, starting right after edge T+LAT.
- R4: `rsp_data` equals `(A*40503 + 23130) mod 2**DATA_W`, where A is the full request address.
- R5: `rsp_addr` equals the address of the request being answered.
- R6: Responses leave in the same order their requests were accepted, at most one per cycle.
- R7: A stream of requests that visits the banks in turn is accepted one per cycle without a stall, as long as there are at least `LAT` banks.
- R8: After synchronous reset, `rsp_valid` is low and every bank is free, so `req_ready` is high.
- R9: A cycle where the request is not accepted (`req_valid` low, or `req_ready` low) produces no response and does not occupy any bank.
- R10: The same bank can accept again exactly `LAT` edges after its previous acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read request is offered |
| req_addr | input | ADDR_W | Read address; low bits choose the bank |
| req_ready | output | 1 | Addressed bank is free to take the request |
| rsp_valid | output | 1 | Response word is present this cycle |
| rsp_addr | output | ADDR_W | Address the response belongs to |
| rsp_data | output | DATA_W | Word read from that address |

## Verification
The assertions take for granted that reset is applied before the first request. They also assume `LAT` is small enough that the in-order queue never holds more than `LAT` entries. Beyond that they assume nothing about the request stream: a refused request may be held, changed or withdrawn. The stimulus uses both behaviours. Some phases hold a request until it is accepted, and one phase drops requests that are refused or idle. Addresses come from linear, same-bank and pseudo-random phases, so busy-bank stalls and overlapping accesses both occur.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Fixed content pattern of the read-only storage, as a function of the full address.
  function automatic logic [31:0] word_of(input logic [31:0] addr);
    return addr * 32'd40503 + 32'd23130;
  endfunction

endpackage

// File: rtl/ilv_order_fifo.sv
module ilv_order_fifo #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign empty = (level == '0);
  assign full  = (level == CNT_W'(DEPTH));

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push && !pop |-> !full);   // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);          // R6
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int BANK_ID   = 0,
  parameter int BANK_BITS = 2,
  parameter int LOC_W     = 8,
  parameter int DATA_W    = 16,
  parameter int LAT       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOC_W-1:0]  loc,
  output logic              busy,
  output logic              done,
  output logic [LOC_W-1:0]  loc_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << LOC_W;
  localparam int CNT_W = $clog2(LAT + 1);

  logic [DATA_W-1:0] rom [DEPTH];
  logic [LOC_W-1:0]  mar;
  logic [CNT_W-1:0]  cnt;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] full_addr;
      full_addr = 32'((i << BANK_BITS) | BANK_ID);
      rom[i] = DATA_W'(ilv_pkg::word_of(full_addr));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      cnt <= '0;
    end else if (load) begin
      mar <= loc;
      cnt <= CNT_W'(LAT);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy  = (cnt > CNT_W'(1));
  assign done  = (cnt == CNT_W'(1));
  assign loc_q = mar;
  assign rdata = rom[mar];

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst) load |-> !busy);  // R2
  AST_DONE_STABLE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (LAT > 1) && done |-> $stable(loc_q));                                               // R5
endmodule

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int BANK_BITS = 2,
  parameter int LAT       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int NBANK  = 1 << BANK_BITS;
  localparam int LOC_W  = ADDR_W - BANK_BITS;
  localparam int QDEPTH = 1 << $clog2(LAT + 1);

  logic [BANK_BITS-1:0] sel_bank;
  logic [LOC_W-1:0]     sel_loc;
  logic                 accept;
  logic [NBANK-1:0]     busy, done, load;
  logic [LOC_W-1:0]     loc_q  [NBANK];
  logic [DATA_W-1:0]    rdata  [NBANK];
  logic [BANK_BITS-1:0] head;
  logic                 q_empty, q_full, pop;

  assign sel_bank  = req_addr[BANK_BITS-1:0];
  assign sel_loc   = req_addr[ADDR_W-1:BANK_BITS];
  assign req_ready = !busy[sel_bank];
  assign accept    = req_valid && req_ready;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign load[b] = accept && (sel_bank == BANK_BITS'(b));
    ilv_bank #(
      .BANK_ID(b), .BANK_BITS(BANK_BITS), .LOC_W(LOC_W), .DATA_W(DATA_W), .LAT(LAT)
    ) i_bank (
      .clk(clk), .rst(rst), .load(load[b]), .loc(sel_loc),
      .busy(busy[b]), .done(done[b]), .loc_q(loc_q[b]), .rdata(rdata[b])
    );
  end

  ilv_order_fifo #(.WIDTH(BANK_BITS), .DEPTH(QDEPTH)) i_order (
    .clk(clk), .rst(rst), .push(accept), .din(sel_bank),
    .pop(pop), .dout(head), .empty(q_empty), .full(q_full)
  );

  assign pop = !q_empty && done[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= pop;
      if (pop) begin
        rsp_addr <= {loc_q[head], head};
        rsp_data <= rdata[head];
      end
    end
  end

  AST_ONE_COMPLETION: assert property (@(posedge clk) disable iff (rst) $onehot0(done));         // R6
  AST_DONE_IS_HEAD: assert property (@(posedge clk) disable iff (rst) |done |-> pop);             // R6
  AST_QUEUE_ROOM: assert property (@(posedge clk) disable iff (rst) accept |-> (!q_full || pop)); // R6
  AST_ACCEPT_OCCUPIES: assert property (@(posedge clk) disable iff (rst)
    (LAT > 1) && accept |=> busy[$past(sel_bank)]);                                                 // R2
  AST_RSP_FROM_POP: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(pop));  // R3
endmodule

// File: tb/test_ilv_bank_ctrl.sv
module test_ilv_bank_ctrl;
  localparam int AW = 10, DW = 16, BB = 2, L = 3, NB = 1 << BB;

  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;

  ilv_bank_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BANK_BITS(BB), .LAT(L)) i_ilv_bank_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int remain [NB];
  bit pv [L+1];
  int order_q [$];
  int edge_no = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int data_of(int a);
    return (a * 40503 + 23130) & ((1 << DW) - 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_no);
    end
  endtask

  // One cycle: check outputs, drive, check ready, advance model at the edge.
  task automatic step(input bit v, input int a, output bit acc);
    int b; bit exp_rdy;
    @(negedge clk);
    if (pv[L]) begin
      int ea = order_q.pop_front();
      chk(rsp_valid === 1'b1, "R3 rsp_valid", int'(rsp_valid), 1);
      chk(rsp_addr == AW'(ea), "R5/R6 rsp_addr", int'(rsp_addr), ea);
      chk(rsp_data == DW'(data_of(ea)), "R4 rsp_data", int'(rsp_data), data_of(ea));
    end else begin
      chk(rsp_valid === 1'b0, "R9 no spurious rsp_valid", int'(rsp_valid), 0);
    end
    req_valid = v;
    req_addr  = AW'(a);
    #1;
    b = a % NB;
    exp_rdy = (remain[b] <= 1);
    chk(req_ready === exp_rdy, "R2 req_ready (R1 bank select)", int'(req_ready), int'(exp_rdy));
    @(posedge clk);
    edge_no++;
    acc = v && exp_rdy;
    for (int i = L; i > 0; i--) pv[i] = pv[i-1];
    pv[0] = acc;
    for (int k = 0; k < NB; k++) if (remain[k] > 0) remain[k]--;
    if (acc) begin
      remain[b] = L;
      order_q.push_back(a);
    end
  endtask

  task automatic send(input int a, output int waited);
    bit acc;
    waited = 0;
    step(1'b1, a, acc);
    while (!acc) begin
      waited++;
      step(1'b1, a, acc);
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc; int w, tot, start;
    for (int k = 0; k < NB; k++) remain[k] = 0;
    for (int i = 0; i <= L; i++) pv[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rsp_valid === 1'b0, "R8 reset rsp_valid", int'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R8 reset req_ready", int'(req_ready), 1);

    // R7: banks in turn, one per cycle
    start = edge_no; tot = 0;
    for (int i = 0; i < 32; i++) begin send(i, w); tot += w; end
    chk(tot == 0, "R7 stalls in linear stream", tot, 0);
    chk(edge_no - start == 32, "R7 cycles for 32 requests", edge_no - start, 32);

    // R10: same bank repeatedly, spacing L
    send(8, w);
    for (int i = 1; i < 6; i++) begin
      start = edge_no;
      send(8 + 4 * i, w);
      chk(edge_no - start == L, "R10 same-bank spacing", edge_no - start, L);
    end

    // R9: idle and refused requests are dropped, not held
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], int'(lfsr[15:6]), acc);
    end

    // Scattered addresses, held until accepted
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(int'(lfsr[AW-1:0]), w);
    end

    for (int i = 0; i < L + 4; i++) step(1'b0, 0, acc);
    chk(order_q.size() == 0, "R6 all responses returned", order_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule